// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block owns the program counter and the instruction-set state bit of a core that runs either 32-bit or 16-bit instructions. Every cycle in which an instruction retires (`advance_i`), it picks the next fetch address. That address is a sequential step sized by the current state, a branch target taken from an already decoded branch class, or an external redirect address such as an exception vector. It also updates the state bit and, for call-type branches, presents a return address with a write enable for the link register.

Decode, condition evaluation, the register file and memory are outside the block. The block receives a branch class that has already been resolved, together with its target. It returns the next PC to the fetch unit and the link write to the register file.

The branch class is a 3-bit code: 0 none, 1 jump, 2 call, 3 exchange jump, 4 exchange call. The codes 5 to 7 are treated as none. The state bit is 0 for the 32-bit state and 1 for the 16-bit state.

Top module: `next_pc_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first update, `pc_o` is 0 and `half_o` is 0 (32-bit state).
- R2: With `half_o`=0, an advance with class 0 and no redirect makes `pc_o` grow by 4 at the next clock edge.
- R3: With `half_o`=1, an advance with class 0 and no redirect makes `pc_o` grow by 2 at the next clock edge.
- R4: Class 1 (jump) loads the target with bit 0 cleared, and bit 1 also cleared in the 32-bit state. It keeps `half_o` and leaves `lr_we_o` low.
- R5: Class 2 (call) loads the target aligned as in R4 and keeps `half_o`. In the same cycle it raises `lr_we_o`, and `lr_data_o` is the address of the next sequential instruction.
- R6: Class 3 (exchange jump) sets `half_o` to target bit 0. It loads the target with bit 0 cleared, and bit 1 also cleared when the new state is 32-bit. It leaves `lr_we_o` low.
- R7: Class 4 (exchange call) updates the PC and state as in R6 and writes the link as in R5, all in one cycle.
- R8: In the 16-bit state, bit 0 of `lr_data_o` is 1 on a link write. In the 32-bit state it is 0.
- R9: `redir_i` wins over any branch and over the step. The next PC is `redir_addr_i` with bits 1:0 cleared, `half_o` becomes 0, and `lr_we_o` stays low.
- R10: With `advance_i` and `redir_i` both low, `pc_o` and `half_o` hold and `lr_we_o` is low, whatever the branch class.
- R11: Class codes 5, 6 and 7 behave as class 0: a sequential step with no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| advance_i | input | 1 | Current instruction retires this cycle |
| br_kind_i | input | 3 | Decoded branch class of the current instruction |
| br_target_i | input | AW | Branch target address |
| redir_i | input | 1 | External redirect request |
| redir_addr_i | input | AW | Redirect address |
| pc_o | output | AW | Current program counter |
| half_o | output | 1 | Current state: 1 selects 16-bit instructions |
| next_pc_o | output | AW | Address loaded at the next update |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | AW | Return address for the link register |

## Verification
Directed runs step through long straight-line sequences in each state, so that a swapped step size (2 against 4) shows up as drift. Targets with both low bits set are sent through each class in each state. This separates state-driven alignment from target-driven alignment and exposes a wrong source for the new state bit. Redirects are raised together with every branch class to prove the priority. Stalled cycles with call classes present show that no link write leaks. A seeded random mix of all eight class codes, stalls and redirects is then compared against a reference model in the bench.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [2:0] {
    BR_NONE  = 3'd0,
    BR_JMP   = 3'd1,
    BR_CALL  = 3'd2,
    BR_XJMP  = 3'd3,
    BR_XCALL = 3'd4
  } br_kind_e;
endpackage

// File: rtl/nps_step.sv
module nps_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pc_i,
  input  logic          half_i,
  output logic [AW-1:0] seq_pc_o,
  output logic [AW-1:0] link_o
);
  localparam logic [AW-1:0] STEP_W = AW'(4);
  localparam logic [AW-1:0] STEP_H = AW'(2);

  assign seq_pc_o = pc_i + (half_i ? STEP_H : STEP_W);
  // 16-bit return addresses carry the state in bit 0
  assign link_o   = {seq_pc_o[AW-1:1], half_i};
endmodule

// File: rtl/nps_target.sv
module nps_target #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] target_i,
  input  logic          half_cur_i,
  input  logic          exch_i,
  output logic [AW-1:0] tgt_pc_o,
  output logic          tgt_half_o
);
  always_comb begin
    tgt_half_o = exch_i ? target_i[0] : half_cur_i;
    tgt_pc_o   = {target_i[AW-1:2], target_i[1] & tgt_half_o, 1'b0};
  end
endmodule

// File: rtl/nps_select.sv
module nps_select
  import nps_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          advance_i,
  input  logic [2:0]    kind_i,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic          half_cur_i,
  input  logic [AW-1:0] tgt_pc_i,
  input  logic          tgt_half_i,
  output logic          exch_o,
  output logic          upd_o,
  output logic [AW-1:0] nxt_pc_o,
  output logic          nxt_half_o,
  output logic          link_we_o
);
  logic is_br, is_link;

  always_comb begin
    is_br   = 1'b0;
    is_link = 1'b0;
    exch_o  = 1'b0;
    unique case (kind_i)
      BR_JMP:   is_br = 1'b1;
      BR_CALL:  begin is_br = 1'b1; is_link = 1'b1; end
      BR_XJMP:  begin is_br = 1'b1; exch_o = 1'b1; end
      BR_XCALL: begin is_br = 1'b1; is_link = 1'b1; exch_o = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    upd_o      = redir_i | advance_i;
    link_we_o  = advance_i & ~redir_i & is_link;
    if (redir_i) begin
      nxt_pc_o   = {redir_addr_i[AW-1:2], 2'b00};
      nxt_half_o = 1'b0;
    end else if (is_br) begin
      nxt_pc_o   = tgt_pc_i;
      nxt_half_o = tgt_half_i;
    end else begin
      nxt_pc_o   = seq_pc_i;
      nxt_half_o = half_cur_i;
    end
  end

  always_comb begin
    if (redir_i) assert_redir_no_link_R9: assert (!link_we_o);
    if (!advance_i) assert_stall_no_link_R10: assert (!link_we_o);
  end
endmodule

// File: rtl/next_pc_seq.sv
module next_pc_seq #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          advance_i,
  input  logic [2:0]    br_kind_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  output logic [AW-1:0] pc_o,
  output logic          half_o,
  output logic [AW-1:0] next_pc_o,
  output logic          lr_we_o,
  output logic [AW-1:0] lr_data_o
);
  logic [AW-1:0] pc_q, seq_pc, tgt_pc, nxt_pc;
  logic          half_q, tgt_half, nxt_half, exch, upd;

  nps_step #(.AW(AW)) u_step (
    .pc_i(pc_q), .half_i(half_q), .seq_pc_o(seq_pc), .link_o(lr_data_o)
  );

  nps_target #(.AW(AW)) u_tgt (
    .target_i(br_target_i), .half_cur_i(half_q), .exch_i(exch),
    .tgt_pc_o(tgt_pc), .tgt_half_o(tgt_half)
  );

  nps_select #(.AW(AW)) u_sel (
    .advance_i(advance_i), .kind_i(br_kind_i), .redir_i(redir_i),
    .redir_addr_i(redir_addr_i), .seq_pc_i(seq_pc), .half_cur_i(half_q),
    .tgt_pc_i(tgt_pc), .tgt_half_i(tgt_half), .exch_o(exch), .upd_o(upd),
    .nxt_pc_o(nxt_pc), .nxt_half_o(nxt_half), .link_we_o(lr_we_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      half_q <= 1'b0;
    end else if (upd) begin
      pc_q   <= nxt_pc;
      half_q <= nxt_half;
    end
  end

  assign pc_o      = pc_q;
  assign half_o    = half_q;
  assign next_pc_o = nxt_pc;

  assert_pc_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_o[0] && (half_o || !pc_o[1]));
  assert_link_bit0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> lr_data_o[0] == half_o);
  assert_redir_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> !half_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !redir_i) |=> ($stable(pc_o) && $stable(half_o)));
  assert_seq_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !redir_i && br_kind_i == 3'd0 && !half_o)
      |=> pc_o == $past(pc_o) + AW'(4));
  assert_seq_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !redir_i && br_kind_i == 3'd0 && half_o)
      |=> pc_o == $past(pc_o) + AW'(2));
endmodule

// File: tb/tb_next_pc_seq.sv
`timescale 1ns/1ps
module tb_next_pc_seq;
  localparam int AW = 32;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic advance_i = 1'b0, redir_i = 1'b0;
  logic [2:0] br_kind_i = '0;
  logic [AW-1:0] br_target_i = '0, redir_addr_i = '0;
  logic [AW-1:0] pc_o, next_pc_o, lr_data_o;
  logic half_o, lr_we_o;
  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_pc;
  logic m_half;
  bit done = 0;

  always #2 clk = ~clk;

  next_pc_seq #(.AW(AW)) dut (.*, .clk_i(clk));

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_link(logic [AW-1:0] pc, logic h);
    logic [AW-1:0] s = pc + (h ? 2 : 4);
    return {s[AW-1:1], h};
  endfunction

  function automatic bit exp_we(logic adv, logic rd, logic [2:0] k);
    return adv && !rd && (k == 3'd2 || k == 3'd4);
  endfunction

  // reference model for pc/state after one edge
  task automatic model_step(logic adv, logic [2:0] k, logic [AW-1:0] t,
                            logic rd, logic [AW-1:0] ra);
    logic nh;
    if (rd) begin
      m_pc = {ra[AW-1:2], 2'b00}; m_half = 1'b0;
    end else if (adv) begin
      if (k >= 3'd1 && k <= 3'd4) begin
        nh = (k == 3'd3 || k == 3'd4) ? t[0] : m_half;
        m_pc = {t[AW-1:2], t[1] & nh, 1'b0}; m_half = nh;
      end else m_pc = m_pc + (m_half ? 2 : 4);
    end
  endtask

  // drive at negedge, check link before edge, check state after edge
  task automatic op(string req, logic adv, logic [2:0] k, logic [AW-1:0] t,
                    logic rd, logic [AW-1:0] ra);
    @(negedge clk);
    advance_i = adv; br_kind_i = k; br_target_i = t; redir_i = rd; redir_addr_i = ra;
    #1;
    chk({req, " lr_we"}, AW'(lr_we_o), AW'(exp_we(adv, rd, k)));
    if (exp_we(adv, rd, k)) chk({req, " lr_data R8"}, lr_data_o, exp_link(m_pc, m_half));
    model_step(adv, k, t, rd, ra);
    @(negedge clk);
    chk({req, " pc"}, pc_o, m_pc);
    chk({req, " half"}, AW'(half_o), AW'(m_half));
    advance_i = 0; redir_i = 0; br_kind_i = 0;
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pc = '0; m_half = 0;
    #9;
    chk("R1 pc in reset", pc_o, '0);
    chk("R1 half in reset", AW'(half_o), '0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R1 pc after reset", pc_o, '0);
    chk("R1 half after reset", AW'(half_o), '0);
    for (int i = 0; i < 5; i++) op("R2 seq word", 1, 3'd0, 'hFFFF, 0, 0);
    op("R4 jump word", 1, 3'd1, 32'h0000_1237, 0, 0);
    op("R5 call word", 1, 3'd2, 32'h0000_2003, 0, 0);
    op("R6 xjmp to half", 1, 3'd3, 32'h0000_4003, 0, 0);
    for (int i = 0; i < 5; i++) op("R3 seq half", 1, 3'd0, 0, 0, 0);
    op("R4 jump half", 1, 3'd1, 32'h0000_5007, 0, 0);
    op("R5 R8 call half", 1, 3'd2, 32'h0000_6002, 0, 0);
    op("R7 xcall half->word", 1, 3'd4, 32'h0000_7006, 0, 0);
    op("R7 xcall word->half", 1, 3'd4, 32'h0000_8003, 0, 0);
    op("R6 xjmp to word", 1, 3'd3, 32'h0000_9006, 0, 0);
    op("R10 stall call", 0, 3'd2, 32'h0000_AAAA, 0, 0);
    op("R10 stall xjmp", 0, 3'd3, 32'h0000_BBBB, 0, 0);
    for (int k = 5; k < 8; k++) op("R11 unused code", 1, 3'(k), 32'h0000_CCCC, 0, 0);
    op("R6 xjmp to half", 1, 3'd3, 32'h0000_1001, 0, 0);
    for (int k = 0; k < 8; k++) op("R9 redirect priority", 1, 3'(k), 32'h0000_0FF1, 1, 32'hFFFF_0013);
    op("R9 redirect stalled", 0, 3'd4, 32'h1, 1, 32'h0000_0018);
    for (int i = 0; i < 400; i++) begin
      logic adv, rd;
      adv = ($urandom % 4) != 0;
      rd = ($urandom % 10) == 0;
      op("R2-mix random", adv, 3'($urandom % 8), $urandom, rd, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule